// File: doc/BRIEF.md
# Dual-Channel Phase Comparator with Lock Monitor and Shared Status Output

This block compares the divided reference and divided feedback pulses of two synthesizer loops, named RF and IF. For each loop it produces early and late correction pulses for a charge pump, together with an enable that lets the pump outputs float. It also tracks whether the loop has settled. A single status pin is shared between the two loops and several test views. A 4-bit selection code picks what the pin shows: lock indication for one or both loops, a raw divider pulse, or nothing. Some codes instead drive a fast-settling pull-down or command the loop counters to reset.

The divider inputs are single-cycle strobes that are synchronous to `clk`. Each phase comparator has no dead zone. A strobe on either input sets its own flag. When both flags are high they clear together on the next edge, which leaves a one-cycle coincident pulse. A strobe that arrives in that clearing cycle is kept. The phase error of one comparison is the number of cycles during which exactly one flag is high. A comparison with an error below `LOCK_TOL` counts as good. A loop is reported locked once a programmable number of good comparisons have arrived in a row.

Every port is a plain control or status pin. There is no streaming interface, so no handshake or back-pressure applies.

Top module: `ldo_status_mux`

## Requirements
- R1: A reference strobe sets the channel's internal early flag and a feedback strobe sets its late flag on the next edge. When both flags are high, both clear on the following edge, so a one-cycle coincident pulse appears. A strobe sampled in that clearing cycle sets its flag again.
- R2: With the polarity input high, `*_up_o` shows the early flag and `*_dn_o` shows the late flag. With the polarity input low, the two are swapped.
- R3: While the tri-state input is high, `*_pump_en_o` is 0 and both pump pulses are 0 in the same cycle, whatever the power-down input is doing.
- R4: With tri-state low and power-down high, the pump stays enabled until the edge that completes the next comparison. After that edge it is disabled. Once power-down is released, the pump is enabled again after one edge.
- R5: A comparison is good when its error is below `LOCK_TOL` (2 cycles) and bad otherwise. The lock state is true when the number of consecutive good comparisons is at least `lock_need_i`, where a value of 0 counts as 1. A bad comparison clears the lock state. The count saturates at its maximum.
- R6: Lock codes, with bit order {RF lock, IF lock, RF raw, IF raw}: 4'b0100 shows the IF lock, 4'b1000 the RF lock, and 4'b1100 the AND of both. A locked channel drives the pin high, but the pin goes low in every cycle in which either of that channel's flags is high.
- R7: 4'b0001 passes the IF reference strobe to the pin and 4'b0010 the RF reference strobe. 4'b0101 passes the IF feedback strobe and 4'b0110 the RF feedback strobe. These paths are combinational.
- R8: 4'b0011 asserts `fastlock_o` and holds the pin low.
- R9: 4'b0111 asserts `if_cnt_clr_o`, 4'b1011 asserts `rf_cnt_clr_o`, and 4'b1111 asserts both, with the pin low in each case.
- R10: Code 4'b0000 and the unassigned codes 4'b1001, 4'b1010, 4'b1101 and 4'b1110 hold the pin low and assert no control output, even when both loops are locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rf_ref_i | input | 1 | RF divided reference strobe |
| rf_fb_i | input | 1 | RF divided feedback strobe |
| if_ref_i | input | 1 | IF divided reference strobe |
| if_fb_i | input | 1 | IF divided feedback strobe |
| rf_pol_i | input | 1 | RF polarity (1 = positive VCO slope) |
| if_pol_i | input | 1 | IF polarity |
| rf_hiz_i | input | 1 | RF pump tri-state request |
| if_hiz_i | input | 1 | IF pump tri-state request |
| rf_pwdn_i | input | 1 | RF power-down request |
| if_pwdn_i | input | 1 | IF power-down request |
| sel_i | input | 4 | Status pin selection code |
| lock_need_i | input | LCNT_W | Consecutive good comparisons needed for lock |
| rf_up_o | output | 1 | RF pump up pulse |
| rf_dn_o | output | 1 | RF pump down pulse |
| rf_pump_en_o | output | 1 | RF pump drive enable (0 = floating) |
| if_up_o | output | 1 | IF pump up pulse |
| if_dn_o | output | 1 | IF pump down pulse |
| if_pump_en_o | output | 1 | IF pump drive enable |
| status_o | output | 1 | Shared status/test pin |
| fastlock_o | output | 1 | Fast-settling pull-down active |
| rf_cnt_clr_o | output | 1 | RF counter reset command |
| if_cnt_clr_o | output | 1 | IF counter reset command |

## Verification
A comparison completes on one edge, and two functions act on that same edge: the lock count is updated and synchronous power-down is entered. The bench raises power-down while a comparison is still open. It then checks that the pump stays enabled through the coincident pulse and floats only after the completing edge. It also checks that the lock state, observed on the status pin, still moves on from that same comparison.

// File: rtl/ldo_pkg.sv
package ldo_pkg;
  localparam logic [3:0] SEL_OFF      = 4'b0000;
  localparam logic [3:0] SEL_RAW_IFR  = 4'b0001;
  localparam logic [3:0] SEL_RAW_RFR  = 4'b0010;
  localparam logic [3:0] SEL_FAST     = 4'b0011;
  localparam logic [3:0] SEL_LK_IF    = 4'b0100;
  localparam logic [3:0] SEL_RAW_IFF  = 4'b0101;
  localparam logic [3:0] SEL_RAW_RFF  = 4'b0110;
  localparam logic [3:0] SEL_CLR_IF   = 4'b0111;
  localparam logic [3:0] SEL_LK_RF    = 4'b1000;
  localparam logic [3:0] SEL_CLR_RF   = 4'b1011;
  localparam logic [3:0] SEL_LK_BOTH  = 4'b1100;
  localparam logic [3:0] SEL_CLR_BOTH = 4'b1111;

  localparam int CH_IF = 0;
  localparam int CH_RF = 1;
  localparam int N_CH  = 2;
endpackage

// File: rtl/ldo_phase_det.sv
module ldo_phase_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  input  logic fb_i,
  input  logic pol_i,
  input  logic hiz_i,
  input  logic pwdn_i,
  output logic early_o,
  output logic late_o,
  output logic done_o,
  output logic up_o,
  output logic dn_o,
  output logic pump_en_o
);
  logic early_q, late_q, pd_q, done;

  assign done = early_q & late_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early_q <= 1'b0;
      late_q  <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      early_q <= done ? ref_i : (early_q | ref_i);
      late_q  <= done ? fb_i  : (late_q  | fb_i);
      pd_q    <= pwdn_i ? (pd_q | done) : 1'b0;
    end
  end

  assign pump_en_o = !hiz_i && !pd_q;
  assign up_o      = pump_en_o && (pol_i ? early_q : late_q);
  assign dn_o      = pump_en_o && (pol_i ? late_q : early_q);
  assign early_o   = early_q;
  assign late_o    = late_q;
  assign done_o    = done;

  p_ref_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_i |=> early_q);
  p_fb_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fb_i |=> late_q);
  p_coinc_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ref_i && !fb_i) |=> (!early_q && !late_q));
  p_pd_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_q && !done) |=> !pd_q);
  p_pd_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwdn_i |=> !pd_q);
  p_float_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hiz_i |-> (!up_o && !dn_o && !pump_en_o));
endmodule

// File: rtl/ldo_lock_mon.sv
module ldo_lock_mon #(
  parameter int ERR_W    = 6,
  parameter int LCNT_W   = 3,
  parameter int LOCK_TOL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              early_i,
  input  logic              late_i,
  input  logic              done_i,
  input  logic [LCNT_W-1:0] need_i,
  output logic              locked_o
);
  localparam logic [ERR_W-1:0]  TOL_V   = ERR_W'(LOCK_TOL);
  localparam logic [ERR_W-1:0]  ERR_MAX = '1;
  localparam logic [LCNT_W-1:0] CNT_MAX = '1;

  logic [ERR_W-1:0]  err_q;
  logic [LCNT_W-1:0] good_q;
  logic [LCNT_W-1:0] need_eff;
  logic              open_err;

  assign open_err = early_i ^ late_i;
  assign need_eff = (need_i == '0) ? LCNT_W'(1) : need_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
    end else if (done_i) begin
      err_q <= '0;
      if (err_q < TOL_V)
        good_q <= (good_q == CNT_MAX) ? good_q : good_q + 1'b1;
      else
        good_q <= '0;
    end else if (open_err && err_q != ERR_MAX) begin
      err_q <= err_q + 1'b1;
    end
  end

  assign locked_o = (good_q >= need_eff);

  p_bad_unlocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && err_q >= TOL_V) |=> !locked_o);
  p_lock_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i && $stable(need_i)) |=> $stable(locked_o));
endmodule

// File: rtl/ldo_out_sel.sv
module ldo_out_sel
  import ldo_pkg::*;
(
  input  logic [3:0] sel_i,
  input  logic       lk_if_i,
  input  logic       lk_rf_i,
  input  logic       ref_if_i,
  input  logic       ref_rf_i,
  input  logic       fb_if_i,
  input  logic       fb_rf_i,
  output logic       status_o,
  output logic       fastlock_o,
  output logic       clr_rf_o,
  output logic       clr_if_o
);
  always_comb begin
    status_o   = 1'b0;
    fastlock_o = 1'b0;
    clr_rf_o   = 1'b0;
    clr_if_o   = 1'b0;
    case (sel_i)
      SEL_LK_IF:    status_o = lk_if_i;
      SEL_LK_RF:    status_o = lk_rf_i;
      SEL_LK_BOTH:  status_o = lk_if_i & lk_rf_i;
      SEL_RAW_IFR:  status_o = ref_if_i;
      SEL_RAW_RFR:  status_o = ref_rf_i;
      SEL_RAW_IFF:  status_o = fb_if_i;
      SEL_RAW_RFF:  status_o = fb_rf_i;
      SEL_FAST:     fastlock_o = 1'b1;
      SEL_CLR_IF:   clr_if_o = 1'b1;
      SEL_CLR_RF:   clr_rf_o = 1'b1;
      SEL_CLR_BOTH: begin
        clr_if_o = 1'b1;
        clr_rf_o = 1'b1;
      end
      default: status_o = 1'b0;
    endcase
  end

  always_comb begin
    p_fast_low_r8: assert (!(fastlock_o && status_o));
    p_clr_excl_r9: assert (!((clr_rf_o || clr_if_o) && (status_o || fastlock_o)));
  end
endmodule

// File: rtl/ldo_status_mux.sv
module ldo_status_mux
  import ldo_pkg::*;
#(
  parameter int ERR_W    = 6,
  parameter int LCNT_W   = 3,
  parameter int LOCK_TOL = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_ref_i,
  input  logic              rf_fb_i,
  input  logic              if_ref_i,
  input  logic              if_fb_i,
  input  logic              rf_pol_i,
  input  logic              if_pol_i,
  input  logic              rf_hiz_i,
  input  logic              if_hiz_i,
  input  logic              rf_pwdn_i,
  input  logic              if_pwdn_i,
  input  logic [3:0]        sel_i,
  input  logic [LCNT_W-1:0] lock_need_i,
  output logic              rf_up_o,
  output logic              rf_dn_o,
  output logic              rf_pump_en_o,
  output logic              if_up_o,
  output logic              if_dn_o,
  output logic              if_pump_en_o,
  output logic              status_o,
  output logic              fastlock_o,
  output logic              rf_cnt_clr_o,
  output logic              if_cnt_clr_o
);
  logic [N_CH-1:0] ref_v, fb_v, pol_v, hiz_v, pwdn_v;
  logic [N_CH-1:0] early_v, late_v, done_v, up_v, dn_v, en_v, locked_v, quiet_ok;

  assign ref_v  = {rf_ref_i,  if_ref_i};
  assign fb_v   = {rf_fb_i,   if_fb_i};
  assign pol_v  = {rf_pol_i,  if_pol_i};
  assign hiz_v  = {rf_hiz_i,  if_hiz_i};
  assign pwdn_v = {rf_pwdn_i, if_pwdn_i};

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    ldo_phase_det u_pd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_i    (ref_v[c]),
      .fb_i     (fb_v[c]),
      .pol_i    (pol_v[c]),
      .hiz_i    (hiz_v[c]),
      .pwdn_i   (pwdn_v[c]),
      .early_o  (early_v[c]),
      .late_o   (late_v[c]),
      .done_o   (done_v[c]),
      .up_o     (up_v[c]),
      .dn_o     (dn_v[c]),
      .pump_en_o(en_v[c])
    );

    ldo_lock_mon #(
      .ERR_W   (ERR_W),
      .LCNT_W  (LCNT_W),
      .LOCK_TOL(LOCK_TOL)
    ) u_lk (
      .clk     (clk),
      .rst_n   (rst_n),
      .early_i (early_v[c]),
      .late_i  (late_v[c]),
      .done_i  (done_v[c]),
      .need_i  (lock_need_i),
      .locked_o(locked_v[c])
    );

    assign quiet_ok[c] = locked_v[c] & ~(early_v[c] | late_v[c]);
  end

  ldo_out_sel u_sel (
    .sel_i     (sel_i),
    .lk_if_i   (quiet_ok[CH_IF]),
    .lk_rf_i   (quiet_ok[CH_RF]),
    .ref_if_i  (if_ref_i),
    .ref_rf_i  (rf_ref_i),
    .fb_if_i   (if_fb_i),
    .fb_rf_i   (rf_fb_i),
    .status_o  (status_o),
    .fastlock_o(fastlock_o),
    .clr_rf_o  (rf_cnt_clr_o),
    .clr_if_o  (if_cnt_clr_o)
  );

  assign rf_up_o      = up_v[CH_RF];
  assign rf_dn_o      = dn_v[CH_RF];
  assign rf_pump_en_o = en_v[CH_RF];
  assign if_up_o      = up_v[CH_IF];
  assign if_dn_o      = dn_v[CH_IF];
  assign if_pump_en_o = en_v[CH_IF];

  p_pulse_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_i == SEL_LK_RF) && (early_v[CH_RF] || late_v[CH_RF])) |-> !status_o);
endmodule

// File: tb/ldo_status_mux_bench.sv
`timescale 1ns/1ps
module ldo_status_mux_bench;
  localparam int LCNT_W = 3;
  localparam int TOL    = 2;
  localparam int GMAX   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_ref = 0, rf_fb = 0, if_ref = 0, if_fb = 0;
  logic rf_pol = 1, if_pol = 1, rf_hiz = 0, if_hiz = 0, rf_pwdn = 0, if_pwdn = 0;
  logic [3:0] sel = 4'b0000;
  logic [LCNT_W-1:0] need = '0;
  logic rf_up, rf_dn, rf_en, if_up, if_dn, if_en, status, fastlock, rf_clr, if_clr;

  int checks = 0;
  int errors = 0;
  int good_m [2];
  int cyc = 0;

  always #2.5 clk = ~clk;

  ldo_status_mux u_ldo_status_mux (
    .clk(clk), .rst_n(rst_n),
    .rf_ref_i(rf_ref), .rf_fb_i(rf_fb), .if_ref_i(if_ref), .if_fb_i(if_fb),
    .rf_pol_i(rf_pol), .if_pol_i(if_pol), .rf_hiz_i(rf_hiz), .if_hiz_i(if_hiz),
    .rf_pwdn_i(rf_pwdn), .if_pwdn_i(if_pwdn), .sel_i(sel), .lock_need_i(need),
    .rf_up_o(rf_up), .rf_dn_o(rf_dn), .rf_pump_en_o(rf_en),
    .if_up_o(if_up), .if_dn_o(if_dn), .if_pump_en_o(if_en),
    .status_o(status), .fastlock_o(fastlock), .rf_cnt_clr_o(rf_clr), .if_cnt_clr_o(if_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit lk(input int c);
    int n;
    n = (need == 0) ? 1 : int'(need);
    return good_m[c] >= n;
  endfunction

  function automatic bit up_of(input int c);
    return (c == 1) ? rf_up : if_up;
  endfunction
  function automatic bit dn_of(input int c);
    return (c == 1) ? rf_dn : if_dn;
  endfunction
  function automatic bit pol_of(input int c);
    return (c == 1) ? rf_pol : if_pol;
  endfunction

  function automatic bit exp_status();
    case (sel)
      4'b0100: return lk(0);
      4'b1000: return lk(1);
      4'b1100: return lk(0) && lk(1);
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input int c, input bit r, input bit f);
    rf_ref = (c == 1) ? r : 1'b0;
    rf_fb  = (c == 1) ? f : 1'b0;
    if_ref = (c == 0) ? r : 1'b0;
    if_fb  = (c == 0) ? f : 1'b0;
  endtask

  task automatic do_reset();
    drive(0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    good_m[0] = 0;
    good_m[1] = 0;
    @(negedge clk);
  endtask

  // one comparison on channel c: d > 0 reference leads by d cycles, d < 0 feedback leads
  task automatic cmp(input int c, input int d);
    int n;
    bit in_lock;
    n = (d < 0) ? -d : d;
    in_lock = (sel == 4'b1100) || (c == 0 && sel == 4'b0100) || (c == 1 && sel == 4'b1000);
    for (int s = 0; s <= n; s++) begin
      drive(c, (d >= 0) ? (s == 0) : (s == n), (d >= 0) ? (s == n) : (s == 0));
      @(negedge clk);
      if (s == 0 && n > 0) begin
        bit eu, ed;
        eu = pol_of(c) ? (d > 0) : (d < 0);
        ed = pol_of(c) ? (d < 0) : (d > 0);
        chk(up_of(c) == eu && dn_of(c) == ed, "R1/R2 open flag", {up_of(c), dn_of(c)}, {eu, ed});
        if (in_lock) chk(status == 1'b0, "R6 low during pulse", status, 0);
      end
    end
    chk(up_of(c) && dn_of(c), "R1 coincident pulse", {up_of(c), dn_of(c)}, 3);
    drive(c, 0, 0);
    @(negedge clk);
    good_m[c] = (n < TOL) ? ((good_m[c] < GMAX) ? good_m[c] + 1 : GMAX) : 0;
    chk(!up_of(c) && !dn_of(c), "R1 flags cleared", {up_of(c), dn_of(c)}, 0);
    chk(status == exp_status(), "R5/R6 lock state", status, exp_status());
  endtask

  initial begin : watchdog
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    do_reset();
    sel = 4'b1000;
    chk(status == 0, "R6 reset status", status, 0);
    chk(!rf_up && !rf_dn && !if_up && !if_dn, "R1 reset flags", {rf_up, rf_dn}, 0);
    chk(rf_en && if_en, "R3 reset pump enabled", {rf_en, if_en}, 3);

    // R5/R6: sweep required count, both channels, good phase patterns then a bad one
    for (int nd = 0; nd < 4; nd++) begin
      need = LCNT_W'(nd);
      for (int c = 0; c < 2; c++) begin
        sel = (c == 1) ? 4'b1000 : 4'b0100;
        cmp(c, 4);
        for (int k = 0; k <= nd + 1; k++) cmp(c, (k % 3) - 1);
        cmp(c, (c == 1) ? -2 : 2);
        chk(status == 0, "R5 bad comparison unlocks", status, 0);
      end
    end

    // R5 saturation: many good comparisons, need at max
    need = 3'd7;
    sel = 4'b1000;
    for (int k = 0; k < 10; k++) cmp(1, 1);
    chk(status == 1, "R5 saturated count stays locked", status, 1);

    // R2 polarity swap on both channels
    rf_pol = 0; if_pol = 0;
    cmp(1, 1); cmp(1, -1); cmp(0, 1); cmp(0, -1);
    rf_pol = 1; if_pol = 1;

    // R6 both-lock code
    need = 3'd2;
    sel = 4'b1100;
    cmp(0, 0); cmp(0, 1); cmp(1, 0); cmp(1, -1);
    chk(status == 1, "R6 both locked", status, 1);
    cmp(0, 3);
    chk(status == 0, "R6 both needs both", status, 0);
    cmp(0, 0); cmp(0, 0);
    chk(status == 1, "R6 both relocked", status, 1);

    // R10: off and unassigned codes while both locked
    foreach (good_m[i]) ;
    for (int k = 0; k < 5; k++) begin
      logic [3:0] code;
      code = (k == 0) ? 4'b0000 : (k == 1) ? 4'b1001 : (k == 2) ? 4'b1010 : (k == 3) ? 4'b1101 : 4'b1110;
      sel = code;
      #1;
      chk(!status && !fastlock && !rf_clr && !if_clr, "R10 inert code",
          {status, fastlock, rf_clr, if_clr}, 0);
    end

    // R8 / R9
    sel = 4'b0011; #1;
    chk(fastlock && !status && !rf_clr && !if_clr, "R8 fast lock", {status, fastlock, rf_clr, if_clr}, 4);
    sel = 4'b0111; #1;
    chk(if_clr && !rf_clr && !status && !fastlock, "R9 IF clear", {status, fastlock, rf_clr, if_clr}, 1);
    sel = 4'b1011; #1;
    chk(rf_clr && !if_clr && !status && !fastlock, "R9 RF clear", {status, fastlock, rf_clr, if_clr}, 2);
    sel = 4'b1111; #1;
    chk(rf_clr && if_clr && !status && !fastlock, "R9 both clear", {status, fastlock, rf_clr, if_clr}, 3);

    // R3: tri-state is immediate, also with power-down
    sel = 4'b1000;
    @(negedge clk);
    rf_hiz = 1; #1;
    chk(!rf_en, "R3 hiz floats now", rf_en, 0);
    rf_pwdn = 1;
    drive(1, 1, 0);
    @(negedge clk);
    chk(!rf_en && !rf_up && !rf_dn, "R3 no pulses while floating", {rf_en, rf_up, rf_dn}, 0);
    drive(1, 0, 1);
    @(negedge clk);
    drive(1, 0, 0);
    @(negedge clk);
    good_m[1] = (good_m[1] < GMAX) ? good_m[1] + 1 : GMAX;
    rf_hiz = 0; rf_pwdn = 0;
    @(negedge clk);
    chk(rf_en, "R3 released", rf_en, 1);

    // R4 concurrency: sync power-down raised mid-comparison, lock update on the same edge
    need = 3'd1;
    cmp(1, 3);
    chk(status == 0, "R5 unlocked before concurrency", status, 0);
    rf_pwdn = 1;
    drive(1, 1, 0);
    @(negedge clk);
    chk(rf_en && rf_up, "R4 pump still enabled", {rf_en, rf_up}, 3);
    drive(1, 0, 1);
    @(negedge clk);
    chk(rf_en && rf_up && rf_dn, "R4 enabled through coincident pulse", {rf_en, rf_up, rf_dn}, 7);
    drive(1, 0, 0);
    @(negedge clk);
    chk(!rf_en, "R4 floats after completion", rf_en, 0);
    chk(status == 1, "R5 lock advanced on power-down edge", status, 1);
    @(negedge clk);
    chk(!rf_en, "R4 stays floating", rf_en, 0);
    rf_pwdn = 0;
    @(negedge clk);
    chk(rf_en, "R4 re-enabled after release", rf_en, 1);

    // R1: strobe in the clearing cycle is retained
    do_reset();
    drive(0, 1, 1);
    @(negedge clk);
    drive(0, 1, 0);
    @(negedge clk);
    chk(if_up && !if_dn, "R1 clearing-cycle strobe kept", {if_up, if_dn}, 2);
    drive(0, 0, 1);
    @(negedge clk);
    drive(0, 0, 0);
    @(negedge clk);

    // R7 raw divider paths
    for (int k = 0; k < 4; k++) begin
      logic [3:0] code;
      code = (k == 0) ? 4'b0001 : (k == 1) ? 4'b0010 : (k == 2) ? 4'b0101 : 4'b0110;
      sel = code;
      for (int p = 0; p < 4; p++) begin
        bit exp;
        if_ref = (p == 0); rf_ref = (p == 1); if_fb = (p == 2); rf_fb = (p == 3);
        #1;
        exp = (p == k);
        chk(status == exp, "R7 raw divider view", status, exp);
        @(negedge clk);
      end
      drive(0, 0, 0);
      do_reset();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule